// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a link to a 64-word by 16-bit serial EEPROM that uses a select line, a serial clock and separate data-in and data-out wires. A client hands over one command at a time through a valid/ready handshake. A command is an operation code, a 6-bit word address and, for program commands, a 16-bit data word. The controller turns the command into a serial frame of 9 or 25 clock periods and times every edge from the system clock. For a read, it collects the 16 returned bits. It finishes each command with a single-cycle completion pulse.

After any command that programs the array, the controller releases the select line and raises it again. It then watches the memory's data-out wire, which stays low while the memory is busy. A poll limit stops the wait and flags an error if the memory never reports ready. All serial timing comes from nanosecond parameters and the system clock period, rounded up to whole cycles: clock half-period, select setup, select low time, status settle time and poll limit.

Top module: `mw_eeprom_host`

## Requirements
- R1: The serial clock is high only while select is high, and each high phase and each low phase lasts at least ceil(SCK_HALF_NS/CLK_PERIOD_NS) system cycles.
- R2: Select is high for at least ceil(CS_SETUP_NS/CLK_PERIOD_NS) cycles before the first rising serial clock edge of a frame.
- R3: Between two intervals with select high, select stays low for at least ceil(CS_DESEL_NS/CLK_PERIOD_NS) cycles.
- R4: Data-in changes only while the serial clock is low. It holds its value through each high phase and on the cycle the clock rises.
- R5: A frame starts with a 1 bit. Two opcode bits follow, then six address bits, all sent most significant bit first. The req_op encoding is 0=read (opcode 10), 1=write (01), 2=erase (11), 3=enable programming (00, address prefix 11), 4=disable programming (00, prefix 00), 5=erase all (00, prefix 10) and 6=write all (00, prefix 01). For the four 00 opcodes the remaining address bits are 0. Code 7 is reserved.
- R6: Read, write and write-all frames are 25 clock periods long, and the write data follows the address MSB first. The other commands are 9 periods long.
- R7: For a read, data-out is sampled at the end of the high phase of clocks 10 through 25, bit 15 first. The word appears on rsp_rdata in the cycle rsp_done is high.
- R8: After a program command (write, erase, erase all, write all), select goes low for the deselect time and then high again. After a status settle time the controller polls data-out and completes only after it reads high.
- R9: If data-out is not seen high within ceil(POLL_LIMIT_NS/CLK_PERIOD_NS) poll cycles, rsp_err is high with rsp_done. It is low for every command that completes normally.
- R10: req_ready falls in the cycle after a request is accepted and stays low until rsp_done has pulsed for exactly one cycle. It is high in the cycle after rsp_done, so a request held during the pulse is accepted one cycle later.
- R11: After reset, select, serial clock, data-in, rsp_done and rsp_err are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_op | input | 3 | Operation code (R5 encoding) |
| req_addr | input | AW (6) | Word address |
| req_wdata | input | DW (16) | Data for write and write all |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW (16) | Read word, valid with rsp_done |
| rsp_err | output | 1 | Status poll timed out, valid with rsp_done |
| mw_cs | output | 1 | Memory select |
| mw_sk | output | 1 | Serial clock to the memory |
| mw_di | output | 1 | Serial data toward the memory |
| mw_do | input | 1 | Serial data and ready/busy status from the memory |

## Verification
Two events can fall in the same cycle: the completion pulse of one command and a waiting request for the next. The bench driver sets req_valid as soon as its previous request has been accepted, so every command after the first is already pending while the previous one ends, including the last cycle of the final deselect gap and the done cycle. The bench judges this by checking that ready is low during the pulse and high in the next cycle. It also checks that the bench memory model decodes the following frame correctly and that the scoreboard pops responses in issue order.

// File: rtl/mwh_pkg.sv
package mwh_pkg;

   typedef enum logic [2:0] {
      MWH_READ  = 3'd0,
      MWH_WRITE = 3'd1,
      MWH_ERASE = 3'd2,
      MWH_WEN   = 3'd3,
      MWH_WDS   = 3'd4,
      MWH_ERAL  = 3'd5,
      MWH_WRAL  = 3'd6
   } mwh_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_LOW,
      ST_HIGH,
      ST_GAP,
      ST_STSET,
      ST_POLL,
      ST_FIN
   } mwh_state_e;

   // two-bit opcode sent after the start bit
   function automatic logic [1:0] op_code(input mwh_op_e op);
      case (op)
         MWH_READ:  return 2'b10;
         MWH_WRITE: return 2'b01;
         MWH_ERASE: return 2'b11;
         default:   return 2'b00;
      endcase
   endfunction

   // leading address bits that select a special command under opcode 00
   function automatic logic [1:0] op_prefix(input mwh_op_e op);
      case (op)
         MWH_WEN:  return 2'b11;
         MWH_ERAL: return 2'b10;
         MWH_WRAL: return 2'b01;
         default:  return 2'b00;
      endcase
   endfunction

   function automatic logic op_is_long(input mwh_op_e op);
      return (op == MWH_READ) || (op == MWH_WRITE) || (op == MWH_WRAL);
   endfunction

   function automatic logic op_programs(input mwh_op_e op);
      return (op == MWH_WRITE) || (op == MWH_ERASE) ||
             (op == MWH_ERAL)  || (op == MWH_WRAL);
   endfunction

   function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
      return (a + b - 1) / b;
   endfunction

   function automatic int unsigned at_least_one(input int unsigned a);
      return (a == 0) ? 1 : a;
   endfunction

endpackage

// File: rtl/mwh_timer.sv
module mwh_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/mwh_sync.sv
module mwh_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= '0;
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++)
                  r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mwh_shift.sv
module mwh_shift #(
   parameter int unsigned W = 25
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         advance,
   output logic         msb
);

   logic [W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr <= '0;
      else if (load)
         sr <= load_val;
      else if (advance)
         sr <= {sr[W-2:0], 1'b0};
   end

   assign msb = sr[W-1];

endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
   import mwh_pkg::*;
#(
   parameter int unsigned AW             = 6,
   parameter int unsigned DW             = 16,
   parameter int unsigned CLK_PERIOD_NS  = 4,
   parameter int unsigned SCK_HALF_NS    = 500,
   parameter int unsigned CS_SETUP_NS    = 50,
   parameter int unsigned CS_DESEL_NS    = 100,
   parameter int unsigned STATUS_NS      = 100,
   parameter int unsigned POLL_LIMIT_NS  = 20_000_000,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [2:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_done,
   output logic [DW-1:0] rsp_rdata,
   output logic          rsp_err,
   output logic          mw_cs,
   output logic          mw_sk,
   output logic          mw_di,
   input  logic          mw_do
);

   localparam int unsigned HALF_CYC  = at_least_one(ceil_div(SCK_HALF_NS, CLK_PERIOD_NS));
   localparam int unsigned SETUP_CYC = at_least_one(ceil_div(CS_SETUP_NS, CLK_PERIOD_NS));
   localparam int unsigned DESEL_CYC = at_least_one(ceil_div(CS_DESEL_NS, CLK_PERIOD_NS));
   localparam int unsigned STAT_CYC  = at_least_one(ceil_div(STATUS_NS, CLK_PERIOD_NS) + SYNC_STAGES);
   localparam int unsigned POLL_CYC  = at_least_one(ceil_div(POLL_LIMIT_NS, CLK_PERIOD_NS));
   localparam int unsigned PH_MAX1   = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
   localparam int unsigned PH_MAX2   = (DESEL_CYC > STAT_CYC) ? DESEL_CYC : STAT_CYC;
   localparam int unsigned PH_MAX    = (PH_MAX1 > PH_MAX2) ? PH_MAX1 : PH_MAX2;
   localparam int unsigned TW        = $clog2(PH_MAX + 1);
   localparam int unsigned PW        = $clog2(POLL_CYC + 1);
   localparam int unsigned SW        = 3 + AW;
   localparam int unsigned FW        = SW + DW;
   localparam int unsigned BW        = $clog2(FW + 1);

   generate
      if (AW < 3) begin : g_bad_aw
         $error("mw_eeprom_host: AW must be at least 3");
      end
      if (DW < 1) begin : g_bad_dw
         $error("mw_eeprom_host: DW must be at least 1");
      end
      if (CLK_PERIOD_NS == 0) begin : g_bad_clk
         $error("mw_eeprom_host: CLK_PERIOD_NS must be non-zero");
      end
      if (SYNC_STAGES > 3) begin : g_bad_sync
         $error("mw_eeprom_host: SYNC_STAGES above 3 is not supported");
      end
   endgenerate

   mwh_state_e st, st_n;
   mwh_op_e    op_in, op_q;
   logic          long_q, prog_q, polled_q, err_q;
   logic [BW-1:0] bit_idx;
   logic [DW-1:0] rdata_q;

   logic          t_load, t_exp, p_load, p_exp;
   logic [TW-1:0] t_val;
   logic          sh_load, sh_adv, sh_msb;
   logic          do_s;
   logic [FW-1:0] frame_in;
   logic [AW-1:0] addr_f;
   logic          accept, last_bit;

   assign op_in  = mwh_op_e'(req_op);
   assign accept = (st == ST_IDLE) && req_valid;

   // address field: special commands replace it with a prefix and zeros
   always_comb begin
      if (op_code(op_in) == 2'b00)
         addr_f = {op_prefix(op_in), {(AW-2){1'b0}}};
      else
         addr_f = req_addr;
      if (op_is_long(op_in) && (op_in != MWH_READ))
         frame_in = {1'b1, op_code(op_in), addr_f, req_wdata};
      else
         frame_in = {1'b1, op_code(op_in), addr_f, {DW{1'b0}}};
   end

   assign last_bit = long_q ? (bit_idx == BW'(FW - 1)) : (bit_idx == BW'(SW - 1));

   mwh_timer #(.W(TW)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_exp)
   );

   mwh_timer #(.W(PW)) u_poll (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (p_load),
      .load_val (PW'(POLL_CYC - 1)),
      .expired  (p_exp)
   );

   mwh_shift #(.W(FW)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (frame_in),
      .advance  (sh_adv),
      .msb      (sh_msb)
   );

   mwh_sync #(.STAGES(SYNC_STAGES)) u_dosync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mw_do),
      .q     (do_s)
   );

   // next state and phase timer control
   always_comb begin
      st_n    = st;
      t_load  = 1'b0;
      t_val   = '0;
      p_load  = 1'b0;
      sh_load = 1'b0;
      sh_adv  = 1'b0;
      case (st)
         ST_IDLE: begin
            if (req_valid) begin
               st_n    = ST_SETUP;
               t_load  = 1'b1;
               t_val   = TW'(SETUP_CYC - 1);
               sh_load = 1'b1;
            end
         end
         ST_SETUP: begin
            if (t_exp) begin
               st_n   = ST_LOW;
               t_load = 1'b1;
               t_val  = TW'(HALF_CYC - 1);
            end
         end
         ST_LOW: begin
            if (t_exp) begin
               st_n   = ST_HIGH;
               t_load = 1'b1;
               t_val  = TW'(HALF_CYC - 1);
            end
         end
         ST_HIGH: begin
            if (t_exp) begin
               t_load = 1'b1;
               if (last_bit) begin
                  st_n  = ST_GAP;
                  t_val = TW'(DESEL_CYC - 1);
               end else begin
                  st_n   = ST_LOW;
                  t_val  = TW'(HALF_CYC - 1);
                  sh_adv = 1'b1;
               end
            end
         end
         ST_GAP: begin
            if (t_exp) begin
               if (prog_q && !polled_q) begin
                  st_n   = ST_STSET;
                  t_load = 1'b1;
                  t_val  = TW'(STAT_CYC - 1);
               end else begin
                  st_n = ST_FIN;
               end
            end
         end
         ST_STSET: begin
            if (t_exp) begin
               st_n   = ST_POLL;
               p_load = 1'b1;
            end
         end
         ST_POLL: begin
            if (do_s || p_exp) begin
               st_n   = ST_GAP;
               t_load = 1'b1;
               t_val  = TW'(DESEL_CYC - 1);
            end
         end
         ST_FIN:  st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op_q     <= MWH_READ;
         long_q   <= 1'b0;
         prog_q   <= 1'b0;
         polled_q <= 1'b0;
         err_q    <= 1'b0;
         bit_idx  <= '0;
         rdata_q  <= '0;
      end else begin
         st <= st_n;
         if (accept) begin
            op_q     <= op_in;
            long_q   <= op_is_long(op_in);
            prog_q   <= op_programs(op_in);
            polled_q <= 1'b0;
            err_q    <= 1'b0;
            bit_idx  <= '0;
         end
         if ((st == ST_HIGH) && t_exp) begin
            if (!last_bit)
               bit_idx <= bit_idx + 1'b1;
            if ((op_q == MWH_READ) && (bit_idx >= BW'(SW)))
               rdata_q <= {rdata_q[DW-2:0], do_s};
         end
         if (st == ST_POLL) begin
            if (do_s) begin
               polled_q <= 1'b1;
            end else if (p_exp) begin
               polled_q <= 1'b1;
               err_q    <= 1'b1;
            end
         end
      end
   end

   assign req_ready = (st == ST_IDLE);
   assign rsp_done  = (st == ST_FIN);
   assign rsp_rdata = rdata_q;
   assign rsp_err   = err_q;
   assign mw_cs     = (st == ST_SETUP) || (st == ST_LOW) || (st == ST_HIGH) ||
                      (st == ST_STSET) || (st == ST_POLL);
   assign mw_sk     = (st == ST_HIGH);
   assign mw_di     = ((st == ST_SETUP) || (st == ST_LOW) || (st == ST_HIGH)) && sh_msb;

endmodule

// File: rtl/mwh_checker.sv
module mwh_checker #(
   parameter int unsigned HALF_CYC  = 1,
   parameter int unsigned DESEL_CYC = 1
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic rsp_done,
   input logic mw_cs,
   input logic mw_sk,
   input logic mw_di
);

   int unsigned hi_cnt, lo_cnt, cs_lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt    <= 0;
         lo_cnt    <= 0;
         cs_lo_cnt <= DESEL_CYC;
      end else begin
         hi_cnt    <= mw_sk ? hi_cnt + 1 : 0;
         lo_cnt    <= (mw_cs && !mw_sk) ? lo_cnt + 1 : 0;
         cs_lo_cnt <= mw_cs ? 0 : ((cs_lo_cnt < DESEL_CYC) ? cs_lo_cnt + 1 : cs_lo_cnt);
      end
   end

   // R1
   sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mw_sk |-> mw_cs);

   // R1
   sk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mw_sk) |-> (hi_cnt >= HALF_CYC));

   // R1
   sk_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mw_sk) |-> (lo_cnt >= HALF_CYC));

   // R3
   cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mw_cs) |-> (cs_lo_cnt >= DESEL_CYC));

   // R4
   di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mw_sk |-> $stable(mw_di));

   // R10
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> (!rsp_done && req_ready));

   // R10
   no_done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !req_ready);

endmodule

bind mw_eeprom_host mwh_checker #(
   .HALF_CYC  (HALF_CYC),
   .DESEL_CYC (DESEL_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_done  (rsp_done),
   .mw_cs     (mw_cs),
   .mw_sk     (mw_sk),
   .mw_di     (mw_di)
);

// File: tb/sim_mw_eeprom_host.sv
`timescale 1ns/1ps
module sim_mw_eeprom_host;
   import mwh_pkg::*;

   localparam int HALF = 10;   // 40 ns / 4 ns
   localparam int SETC = 13;   // 50 ns / 4 ns rounded up
   localparam int DESC = 25;   // 100 ns / 4 ns

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_op = 3'd0;
   logic [5:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_done, rsp_err, mw_cs, mw_sk, mw_di, mw_do;
   logic [15:0] rsp_rdata;

   always #2 clk = ~clk;

   mw_eeprom_host #(
      .CLK_PERIOD_NS (4),
      .SCK_HALF_NS   (40),
      .CS_SETUP_NS   (50),
      .CS_DESEL_NS   (100),
      .STATUS_NS     (100),
      .POLL_LIMIT_NS (8000)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
   );

   int n_run = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- memory model ----------------
   logic [15:0] mem [64];
   logic        pcs = 1'b0, psk = 1'b0, pdi = 1'b0;
   logic [24:0] sr = '0;
   logic [5:0]  ra = '0;
   logic        do_q = 1'b1, rd_act = 1'b0, pend = 1'b0, m_en = 1'b0;
   int          bitn = 0, exp_len = 0, busy = 0, busy_len = 300;
   int          cs_hi_cyc = 0, cs_lo_cyc = 1000, sk_cyc = 0;

   initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;

   assign mw_do = !mw_cs ? 1'b1 : (rd_act ? do_q : (busy == 0));

   always @(negedge clk) begin
      if (busy > 0) busy--;
      if (mw_cs && !pcs) begin
         chk(cs_lo_cyc >= DESC, "R3 select low time", cs_lo_cyc, DESC);
         bitn = 0; sr = '0; cs_hi_cyc = 0; exp_len = 0;
      end
      if (!mw_cs && pcs) begin
         if (bitn != 0) chk(bitn == exp_len, "R6 frame length", bitn, exp_len);
         rd_act = 1'b0;
         if (pend) begin busy = busy_len; pend = 1'b0; end
         cs_lo_cyc = 0;
      end
      if (!mw_sk && psk)
         chk(sk_cyc >= HALF, "R1 clock high time", sk_cyc, HALF);
      if (mw_sk && !psk) begin
         if (bitn == 0) chk(cs_hi_cyc >= SETC, "R2 select setup", cs_hi_cyc, SETC);
         chk(mw_di == pdi, "R4 data-in at rising edge", mw_di, pdi);
         sr = {sr[23:0], mw_di};
         bitn++;
         sk_cyc = 0;
         if (bitn == 9) begin
            chk(sr[8] == 1'b1, "R5 start bit", sr[8], 1);
            exp_len = 9;
            case (sr[7:6])
               2'b10: begin rd_act = 1'b1; ra = sr[5:0]; do_q = 1'b0; exp_len = 25; end
               2'b01: exp_len = 25;
               2'b11: begin if (m_en) mem[sr[5:0]] = 16'hFFFF; pend = 1'b1; end
               default: case (sr[5:4])
                  2'b11: m_en = 1'b1;
                  2'b00: m_en = 1'b0;
                  2'b10: begin
                     if (m_en) for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                     pend = 1'b1;
                  end
                  default: exp_len = 25;
               endcase
            endcase
         end
         if (rd_act && bitn >= 10 && bitn <= 25) do_q = mem[ra][25 - bitn];
         if (bitn == 25) begin
            if (sr[23:22] == 2'b01) begin
               if (m_en) mem[sr[21:16]] = sr[15:0];
               pend = 1'b1;
            end else if (sr[23:22] == 2'b00 && sr[21:20] == 2'b01) begin
               if (m_en) for (int i = 0; i < 64; i++) mem[i] = sr[15:0];
               pend = 1'b1;
            end
         end
      end
      if (mw_sk && psk && (mw_di != pdi))
         chk(1'b0, "R4 data-in moved in high phase", mw_di, pdi);
      if (mw_cs) cs_hi_cyc++; else cs_lo_cyc++;
      if (mw_sk) sk_cyc++;
      pcs = mw_cs; psk = mw_sk; pdi = mw_di;
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      bit          is_rd;
      bit          is_prog;
      logic [15:0] rd;
      bit          err;
   } exp_t;

   exp_t        q[$];
   logic [15:0] shadow [64];
   bit          sh_en = 1'b0;

   initial for (int i = 0; i < 64; i++) shadow[i] = 16'h0000;

   task automatic issue(input mwh_op_e op, input logic [5:0] a, input logic [15:0] d, input bit exp_err);
      exp_t e;
      e.is_rd = (op == MWH_READ);
      e.is_prog = op_programs(op);
      e.rd = 16'h0;
      e.err = exp_err;
      case (op)
         MWH_READ:  e.rd = shadow[a];
         MWH_WRITE: if (sh_en) shadow[a] = d;
         MWH_ERASE: if (sh_en) shadow[a] = 16'hFFFF;
         MWH_WEN:   sh_en = 1'b1;
         MWH_WDS:   sh_en = 1'b0;
         MWH_ERAL:  if (sh_en) for (int i = 0; i < 64; i++) shadow[i] = 16'hFFFF;
         MWH_WRAL:  if (sh_en) for (int i = 0; i < 64; i++) shadow[i] = d;
         default: ;
      endcase
      q.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   bit prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_done)
            chk(req_ready == 1'b1, "R10 ready after done", req_ready, 1);
         if (rsp_done) begin
            chk(req_ready == 1'b0, "R10 ready low during done", req_ready, 0);
            if (q.size() == 0) begin
               chk(1'b0, "R10 unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (e.is_rd) chk(rsp_rdata == e.rd, "R7 read data", rsp_rdata, e.rd);
               chk(rsp_err == e.err, "R9 error flag", rsp_err, e.err);
               if (e.is_prog && !e.err) chk(busy == 0, "R8 completion after ready", busy, 0);
            end
         end
         prev_done = rsp_done;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mw_cs == 1'b0, "R11 select at reset", mw_cs, 0);
      chk(mw_sk == 1'b0, "R11 clock at reset", mw_sk, 0);
      chk(mw_di == 1'b0, "R11 data-in at reset", mw_di, 0);
      chk(req_ready == 1'b1, "R11 ready at reset", req_ready, 1);
      chk(rsp_done == 1'b0 && rsp_err == 1'b0, "R11 response at reset", {rsp_done, rsp_err}, 0);

      // programming disabled: write is dropped by the memory
      issue(MWH_WDS,   6'd0,  16'h0000, 1'b0);
      issue(MWH_WRITE, 6'd5,  16'h1111, 1'b0);
      issue(MWH_READ,  6'd5,  16'h0000, 1'b0);
      // enabled writes at both ends of the address range
      issue(MWH_WEN,   6'd0,  16'h0000, 1'b0);
      issue(MWH_WRITE, 6'd5,  16'hA5C3, 1'b0);
      issue(MWH_WRITE, 6'd63, 16'h1234, 1'b0);
      issue(MWH_WRITE, 6'd0,  16'h8001, 1'b0);
      issue(MWH_READ,  6'd5,  16'h0000, 1'b0);
      issue(MWH_READ,  6'd63, 16'h0000, 1'b0);
      issue(MWH_READ,  6'd0,  16'h0000, 1'b0);
      issue(MWH_ERASE, 6'd5,  16'h0000, 1'b0);
      issue(MWH_READ,  6'd5,  16'h0000, 1'b0);
      issue(MWH_READ,  6'd63, 16'h0000, 1'b0);
      issue(MWH_WRAL,  6'd0,  16'h0F0F, 1'b0);
      issue(MWH_READ,  6'd40, 16'h0000, 1'b0);
      issue(MWH_ERAL,  6'd0,  16'h0000, 1'b0);
      issue(MWH_READ,  6'd7,  16'h0000, 1'b0);
      issue(MWH_WDS,   6'd0,  16'h0000, 1'b0);
      issue(MWH_WRITE, 6'd3,  16'h0000, 1'b0);
      issue(MWH_READ,  6'd3,  16'h0000, 1'b0);

      // status poll that never sees ready within the limit
      issue(MWH_WEN,   6'd0,  16'h0000, 1'b0);
      busy_len = 2500;
      issue(MWH_WRITE, 6'd9,  16'h5A5A, 1'b1);
      while (q.size() > 0) @(negedge clk);
      busy_len = 300;
      repeat (1000) @(negedge clk);
      issue(MWH_READ,  6'd9,  16'h0000, 1'b0);

      while (q.size() > 0) @(negedge clk);
      repeat (50) @(negedge clk);
      chk(req_ready == 1'b1 && mw_cs == 1'b0, "R10 idle at end", {req_ready, mw_cs}, 2);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule